// File: doc/BRIEF.md
# Socket Select and Address Sequencer

This block runs the selection sequence for an eight-socket cable driver. A write to the one-byte selection register drives the upper nibble to a one-hot socket enable. A value of zero in that nibble picks an internal monitor path instead of a socket. The block then waits a settling time. Next it asks an external serial transmitter to send the lower nibble as a multiplexer address, and it waits a second settling time once the transmitter reports completion.

During the sequence the block raises a selecting flag. A job number written in that time is latched and reported as busy, and it is released to the job controller one cycle after selection ends. Every write to the register restarts the whole sequence from the enable step. This holds when the value has not changed and when a sequence is already running. The new value is never compared with the old one. Both settling waits last `SETTLE_CYCLES` clock cycles, which is 320 by default: 8 µs at 40 MHz.

Top module: `sock_sel_seq`

## Requirements
- R1: Upper nibble values 1 to 8 set exactly bit (value-1) of `sock_en_o` and clear all other bits, from the clock edge that samples the write.
- R2: An upper nibble of 0 sets `mon_sel_o` with `sock_en_o` all zero. Values 9 to 15 clear both. Both cases still run the full timing sequence.
- R3: `tx_start_o` pulses for one cycle exactly `SETTLE_CYCLES` cycles after the write edge, with `tx_addr_o` equal to the lower nibble of the written byte.
- R4: `tx_sending_o` rises together with `tx_start_o` and stays high until the edge that samples `tx_done_i`. A `tx_done_i` pulse outside that phase has no effect.
- R5: `selecting_o` is high from the write edge and falls exactly `SETTLE_CYCLES` cycles after the edge that sampled `tx_done_i`.
- R6: Every write restarts the sequence from the enable step, including a repeated identical value and a write made mid-sequence, and all timing counts from the newest write.
- R7: A nonzero job number written while `selecting_o` is high is held: `busy_o` stays high, and `job_start_o` pulses once, one cycle after `selecting_o` falls, with `job_o` carrying the number.
- R8: A nonzero job written while idle gives a `job_start_o` pulse on the next clock edge.
- R9: Writing job number 0 cancels a pending job, so no `job_start_o` pulse follows.
- R10: During reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_we_i | input | 1 | Write strobe for the selection register |
| sel_wdata_i | input | 8 | Byte written: upper nibble socket, lower nibble multiplexer address |
| job_we_i | input | 1 | Write strobe for the job number |
| job_i | input | 6 | Job number written |
| tx_done_i | input | 1 | Transmitter finished the address |
| sock_en_o | output | 8 | One-hot socket enables |
| mon_sel_o | output | 1 | Internal monitor path selected |
| tx_start_o | output | 1 | One-cycle request to send the address |
| tx_addr_o | output | 4 | Address nibble for the transmitter |
| tx_sending_o | output | 1 | Address transmission phase status |
| selecting_o | output | 1 | Selection sequence in progress |
| busy_o | output | 1 | Selecting or a job is pending |
| job_start_o | output | 1 | One-cycle job release |
| job_o | output | 6 | Released job number |

## Verification
The results arrive at the following times after a write sampled at edge E:
- The enables, monitor flag and selecting flag change at E.
- The transmit request comes at E+SETTLE_CYCLES.
- The selecting flag falls SETTLE_CYCLES edges after the edge that sampled the transmitter's done.
- A held job is released one edge later than that. An idle job is released at the edge after its write.

The bench drives inputs on falling edges and samples on the falling edge just after each due edge. It also checks the cycle just before each due edge, so an early or late change by one cycle is caught. Random values, transmitter latencies and mid-sequence rewrites are mixed with directed cases for the monitor nibble, stray done pulses, repeated values and job cancellation.

// File: rtl/sock_pkg.sv
package sock_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETTLE1 = 2'd1,
    ST_SEND    = 2'd2,
    ST_SETTLE2 = 2'd3
  } seq_state_e;

  localparam int unsigned NIB_W = 4;
endpackage

// File: rtl/sock_decode.sv
module sock_decode
  import sock_pkg::*;
#(
  parameter int unsigned NUM_SOCK = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [2*NIB_W-1:0]  wdata_i,
  output logic [NUM_SOCK-1:0] sock_en_o,
  output logic                mon_sel_o,
  output logic [NIB_W-1:0]    addr_o
);
  logic [NIB_W-1:0]    sock_nib;
  logic [NUM_SOCK-1:0] onehot;

  assign sock_nib = wdata_i[2*NIB_W-1:NIB_W];

  for (genvar g = 0; g < NUM_SOCK; g++) begin : g_dec
    assign onehot[g] = (sock_nib == NIB_W'(g + 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sock_en_o <= '0;
      mon_sel_o <= 1'b0;
      addr_o    <= '0;
    end else if (we_i) begin
      sock_en_o <= onehot;
      mon_sel_o <= (sock_nib == '0);
      addr_o    <= wdata_i[NIB_W-1:0];
    end
  end

  assert_onehot_en_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sock_en_o));

  assert_mon_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mon_sel_o |-> (sock_en_o == '0));
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int unsigned SETTLE_CYCLES = 320
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam int unsigned CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (en_i && !done_o)     cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LAST);

  assert_cnt_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/sel_fsm.sv
module sel_fsm
  import sock_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_we_i,
  input  logic tmr_done_i,
  input  logic tx_done_i,
  output logic tmr_clr_o,
  output logic tmr_en_o,
  output logic tx_start_o,
  output logic tx_sending_o,
  output logic selecting_o
);
  seq_state_e state_q, state_d;
  logic       start_d;

  always_comb begin
    state_d = state_q;
    start_d = 1'b0;
    if (sel_we_i) begin
      state_d = ST_SETTLE1;
    end else begin
      unique case (state_q)
        ST_SETTLE1: if (tmr_done_i) begin
          state_d = ST_SEND;
          start_d = 1'b1;
        end
        ST_SEND:    if (tx_done_i)  state_d = ST_SETTLE2;
        ST_SETTLE2: if (tmr_done_i) state_d = ST_IDLE;
        default:    state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      tx_start_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      tx_start_o <= start_d;
    end
  end

  assign tmr_clr_o    = sel_we_i || (state_q == ST_SEND && tx_done_i);
  assign tmr_en_o     = (state_q == ST_SETTLE1) || (state_q == ST_SETTLE2);
  assign tx_sending_o = (state_q == ST_SEND);
  assign selecting_o  = (state_q != ST_IDLE);

  assert_start_in_send_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> tx_sending_o);

  assert_send_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_sending_o && !tx_done_i && !sel_we_i) |=> tx_sending_o);

  assert_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_we_i |=> (selecting_o && !tx_sending_o && !tx_start_o));
endmodule

// File: rtl/job_gate.sv
module job_gate #(
  parameter int unsigned JOB_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             job_we_i,
  input  logic [JOB_W-1:0] job_i,
  input  logic             hold_i,
  output logic             pend_o,
  output logic             job_start_o,
  output logic [JOB_W-1:0] job_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o      <= 1'b0;
      job_start_o <= 1'b0;
      job_o       <= '0;
    end else begin
      job_start_o <= 1'b0;
      if (job_we_i) begin
        if (job_i != '0) begin
          pend_o <= 1'b1;
          job_o  <= job_i;
        end else begin
          pend_o <= 1'b0;
        end
      end else if (pend_o && !hold_i) begin
        job_start_o <= 1'b1;
        pend_o      <= 1'b0;
      end
    end
  end

  assert_cancel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (job_we_i && job_i == '0) |=> (!pend_o && !job_start_o));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && hold_i) |=> !job_start_o);
endmodule

// File: rtl/sock_sel_seq.sv
module sock_sel_seq
  import sock_pkg::*;
#(
  parameter int unsigned NUM_SOCK      = 8,
  parameter int unsigned SETTLE_CYCLES = 320,
  parameter int unsigned JOB_W         = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_we_i,
  input  logic [7:0]          sel_wdata_i,
  input  logic                job_we_i,
  input  logic [JOB_W-1:0]    job_i,
  input  logic                tx_done_i,
  output logic [NUM_SOCK-1:0] sock_en_o,
  output logic                mon_sel_o,
  output logic                tx_start_o,
  output logic [3:0]          tx_addr_o,
  output logic                tx_sending_o,
  output logic                selecting_o,
  output logic                busy_o,
  output logic                job_start_o,
  output logic [JOB_W-1:0]    job_o
);
  logic tmr_clr, tmr_en, tmr_done, pend;

  sock_decode #(.NUM_SOCK(NUM_SOCK)) u_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (sel_we_i),
    .wdata_i   (sel_wdata_i),
    .sock_en_o (sock_en_o),
    .mon_sel_o (mon_sel_o),
    .addr_o    (tx_addr_o)
  );

  settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .en_i   (tmr_en),
    .done_o (tmr_done)
  );

  sel_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_we_i     (sel_we_i),
    .tmr_done_i   (tmr_done),
    .tx_done_i    (tx_done_i),
    .tmr_clr_o    (tmr_clr),
    .tmr_en_o     (tmr_en),
    .tx_start_o   (tx_start_o),
    .tx_sending_o (tx_sending_o),
    .selecting_o  (selecting_o)
  );

  job_gate #(.JOB_W(JOB_W)) u_job (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .job_we_i    (job_we_i),
    .job_i       (job_i),
    .hold_i      (selecting_o || sel_we_i),
    .pend_o      (pend),
    .job_start_o (job_start_o),
    .job_o       (job_o)
  );

  assign busy_o = selecting_o || pend;

  assert_job_after_sel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    job_start_o |-> !selecting_o);

  assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !selecting_o |-> (!tx_sending_o && !tx_start_o));
endmodule

// File: tb/sock_sel_seq_bench.sv
module sock_sel_seq_bench;
  localparam int N = 320;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_we = 1'b0;
  logic [7:0] sel_wdata = '0;
  logic       job_we = 1'b0;
  logic [5:0] job = '0;
  logic       tx_done = 1'b0;
  logic [7:0] sock_en;
  logic       mon_sel, tx_start, tx_sending, selecting, busy, job_start;
  logic [3:0] tx_addr;
  logic [5:0] job_out;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  sock_sel_seq u_sock_sel_seq (
    .clk_i(clk), .rst_ni(rst_ni), .sel_we_i(sel_we), .sel_wdata_i(sel_wdata),
    .job_we_i(job_we), .job_i(job), .tx_done_i(tx_done),
    .sock_en_o(sock_en), .mon_sel_o(mon_sel), .tx_start_o(tx_start),
    .tx_addr_o(tx_addr), .tx_sending_o(tx_sending), .selecting_o(selecting),
    .busy_o(busy), .job_start_o(job_start), .job_o(job_out)
  );

  function automatic logic [7:0] exp_en(input logic [3:0] nib);
    return (nib >= 4'd1 && nib <= 4'd8) ? (8'd1 << (nib - 4'd1)) : 8'd0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // full sequence; jv!=0 writes a job during settle 1, cancel writes job 0 after it
  task automatic do_select(input logic [7:0] v, input int lat, input logic [5:0] jv,
                           input bit cancel, input bit stray);
    bit early = 1'b0;
    bit exp_start;
    @(negedge clk);
    sel_we = 1'b1; sel_wdata = v;
    @(negedge clk);
    sel_we = 1'b0;
    chk(sock_en == exp_en(v[7:4]), "R1 enable", sock_en, exp_en(v[7:4]));
    chk(mon_sel == (v[7:4] == 4'd0), "R2 monitor", mon_sel, v[7:4] == 4'd0);
    chk(selecting && !tx_sending, "R6 restart", {selecting, tx_sending}, 2);
    for (int k = 1; k < N; k++) begin
      @(negedge clk);
      job_we = 1'b0; tx_done = 1'b0;
      if (k == 2 && jv != 0) begin job_we = 1'b1; job = jv; end
      if (k == 4 && cancel)  begin job_we = 1'b1; job = 6'd0; end
      if (k == 1 && stray)   tx_done = 1'b1;
      if (tx_start || tx_sending || job_start) early = 1'b1;
    end
    job_we = 1'b0; tx_done = 1'b0;
    chk(!early, "R3 no early start", early, 0);
    @(negedge clk);
    chk(tx_start && tx_sending, "R3 start due", {tx_start, tx_sending}, 3);
    chk(tx_addr == v[3:0], "R3 addr", tx_addr, v[3:0]);
    for (int j = 1; j <= lat; j++) begin
      @(negedge clk);
      if (j == 1) chk(!tx_start, "R3 single pulse", tx_start, 0);
      if (j == lat) chk(tx_sending, "R4 hold", tx_sending, 1);
      if (j == lat) tx_done = 1'b1;
    end
    @(negedge clk);
    tx_done = 1'b0;
    chk(!tx_sending && selecting, "R4 done", {tx_sending, selecting}, 1);
    early = 1'b0;
    for (int k = 1; k < N; k++) begin
      @(negedge clk);
      if (!selecting || job_start) early = 1'b1;
    end
    chk(!early, "R5 second wait", early, 0);
    exp_start = (jv != 0) && !cancel;
    @(negedge clk);
    chk(!selecting, "R5 end", selecting, 0);
    chk(busy == exp_start && !job_start, exp_start ? "R7 held" : "R9 no pend",
        {busy, job_start}, {exp_start, 1'b0});
    @(negedge clk);
    chk(job_start == exp_start, exp_start ? "R7 release" : "R9 cancel", job_start, exp_start);
    if (exp_start) chk(job_out == jv, "R7 job", job_out, jv);
    @(negedge clk);
    chk(!job_start && !busy, "R7 idle", {job_start, busy}, 0);
  endtask

  task automatic partial(input logic [7:0] v, input int cyc);
    @(negedge clk);
    sel_we = 1'b1; sel_wdata = v;
    @(negedge clk);
    sel_we = 1'b0;
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    chk(sock_en == 0 && !mon_sel && !tx_start && !tx_sending && !selecting && !busy
        && !job_start, "R10 reset", {sock_en, mon_sel, selecting, busy}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    do_select(8'h35, 40, 6'd0, 1'b0, 1'b0);        // R1
    do_select(8'h07, 5, 6'd0, 1'b0, 1'b1);         // R2 monitor, R4 stray done
    do_select(8'hA2, 1, 6'd0, 1'b0, 1'b0);         // R2 out of range
    do_select(8'h8F, 10, 6'd0, 1'b0, 1'b0);        // R1 last socket
    do_select(8'h8F, 10, 6'd0, 1'b0, 1'b0);        // R6 same value again
    do_select(8'h14, 20, 6'd11, 1'b0, 1'b0);       // R7
    do_select(8'h26, 20, 6'd3, 1'b1, 1'b0);        // R9
    partial(8'h51, 100);                           // R6 restart in settle 1
    do_select(8'h63, 7, 6'd0, 1'b0, 1'b0);
    partial(8'h42, N + 3);                         // R6 restart during send
    do_select(8'h42, 7, 6'd9, 1'b0, 1'b0);

    // R8 idle job
    @(negedge clk); job_we = 1'b1; job = 6'd12;
    @(negedge clk); job_we = 1'b0;
    chk(busy && !job_start, "R8 latched", {busy, job_start}, 2);
    @(negedge clk);
    chk(job_start && job_out == 6'd12, "R8 start", job_out, 12);

    for (int i = 0; i < 25; i++) begin
      logic [7:0] v;
      v = 8'($urandom);
      if ($urandom_range(0, 2) == 0) partial(8'($urandom), $urandom_range(0, 2 * N));
      do_select(v, $urandom_range(1, 200), 6'($urandom_range(0, 63)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    done_flag = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule